// File: doc/BRIEF.md
# Regulator Startup Sequencer

This block is the digital supervisor of a multiphase buck controller. It drives the reference-voltage code seen by the analog error amplifier, in units of 6.25 mV. When the supply is good and the enable input is high, it waits a fixed delay with the reference at zero and the power stages off. It then switches the drivers on and ramps the reference to a boot level of about 1.081 V. It holds the reference there for a fixed interval. After that it slews the reference to the level selected by the 8-bit voltage-identification code.

Both ramps move one code step every `STEP_CYC` clocks. That count is derived from the programmed soft-start time. Overvoltage and undervoltage comparator flags latch a fault once their checking windows are open. A latched fault zeroes the reference, drops the drivers and clears the soft-start-done flag. The fault stays latched until enable is taken low or the supply-good input drops. The block also reports the overvoltage threshold code, which is the target plus 175 mV, for the comparator.

Top module: `vrs_top`

## Requirements
- R1: While reset is asserted, ref_o is 0 and ss_done_o, fault_o and drv_en_o are 0.
- R2: After en_i and pwr_ok_i are both high, the reference stays 0 and drv_en_o stays low for DELAY_CYC cycles. drv_en_o then rises and ref_o climbs by exactly one code every STEP_CYC cycles. The first step lands 1+DELAY_CYC+STEP_CYC cycles after enable.
- R3: ref_o rests at BOOT_CODE (173, about 1.081 V) for HOLD_CYC cycles after the boot ramp ends, and never moves during that rest.
- R4: After the rest, ref_o slews toward the target at the same one-code-per-STEP_CYC rate. ss_done_o rises in the cycle after ref_o equals the target. From then on ref_o keeps tracking target changes at that rate.
- R5: The target code for vid_i values of 2 and above is 258 minus vid_i, so 0x02 gives 256 (1.600 V), 0x80 gives 130 and 0xFF gives 3. vid_i values 0x00 and 0x01 mean output off, target 0.
- R6: If the target is off when the rest ends, ref_o slews down to 0 and drv_en_o goes low. No fault latches and ss_done_o stays low.
- R7: ov_i is ignored during the delay, the boot ramp and the rest. After the rest, ov_i high latches a fault on the next edge: fault_o goes high, and drv_en_o, ss_done_o and ref_o go to 0.
- R8: uv_i latches the same fault, but only once ss_done_o is high. Before that it is ignored.
- R9: A latched fault stays latched after ov_i and uv_i clear, for as long as en_i and pwr_ok_i stay high. Taking en_i low clears it. en_i high again restarts the sequence from the delay.
- R10: pwr_ok_i low returns the block to idle on the next edge from any state: ref_o is 0, all flags are low and any fault is cleared.
- R11: ovp_ref_o equals the target code plus 28 (175 mV), combinationally from vid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Output enable; a low pulse clears a latched fault |
| pwr_ok_i | input | 1 | Supply above undervoltage lockout |
| vid_i | input | 8 | Voltage-identification code |
| ov_i | input | 1 | Overvoltage comparator flag |
| uv_i | input | 1 | Undervoltage comparator flag |
| ref_o | output | 9 | Reference code, 6.25 mV per LSB |
| ovp_ref_o | output | 9 | Overvoltage threshold code (target + 28) |
| ss_done_o | output | 1 | Soft start complete |
| fault_o | output | 1 | Latched protection fault |
| drv_en_o | output | 1 | Power-stage drivers enable |

## Verification
State and reference changes become visible one clock after the inputs that cause them: fault latching, supply-drop and enable-drop returns to idle, and each ramp step. ovp_ref_o is combinational and is valid in the same cycle that vid_i changes. The bench drives inputs on the falling edge and advances its reference model on the rising edge. It compares every output on the following falling edge, so each expected value is checked in the cycle it is due. Directed checks count whole cycles across the startup delay and the boot rest, so that an off-by-one in either interval is caught.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DELAY, ST_BOOT, ST_HOLD, ST_SLEW, ST_RUN, ST_SHUT, ST_FAULT
  } vrs_state_e;
endpackage

// File: rtl/vrs_vid_map.sv
module vrs_vid_map #(
  parameter int VID_W      = 8,
  parameter int CODE_W     = 9,
  parameter int OFF_CODES  = 2,
  parameter int MAX_CODE   = 256,
  parameter int OVP_MARGIN = 28
) (
  input  logic [VID_W-1:0]  vid_i,
  output logic              off_o,
  output logic [CODE_W-1:0] tgt_o,
  output logic [CODE_W-1:0] ovp_o
);
  localparam int TOP = MAX_CODE + OFF_CODES;

  assign off_o = vid_i < VID_W'(OFF_CODES);
  assign tgt_o = off_o ? '0 : CODE_W'(TOP) - CODE_W'(vid_i);
  assign ovp_o = tgt_o + CODE_W'(OVP_MARGIN);
endmodule

// File: rtl/vrs_interval.sv
module vrs_interval #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + 1'b1;
    else             cnt_q <= '0;

  assign done_o = run_i && (cnt_q == last_i);

  AST_TMR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= last_i); // R3
endmodule

// File: rtl/vrs_slew.sv
module vrs_slew #(
  parameter int CODE_W   = 9,
  parameter int STEP_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              run_i,
  input  logic [CODE_W-1:0] goal_i,
  output logic [CODE_W-1:0] ref_o
);
  localparam int STEP_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

  logic [STEP_W-1:0] step_q;
  logic [CODE_W-1:0] ref_q;
  logic              tick;

  assign tick = run_i && (step_q == STEP_W'(STEP_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      step_q <= '0;
      ref_q  <= '0;
    end else if (clr_i) begin
      step_q <= '0;
      ref_q  <= '0;
    end else if (!run_i) begin
      step_q <= '0;
    end else if (tick) begin
      step_q <= '0;
      if (ref_q < goal_i)      ref_q <= ref_q + 1'b1;
      else if (ref_q > goal_i) ref_q <= ref_q - 1'b1;
    end else begin
      step_q <= step_q + 1'b1;
    end

  assign ref_o = ref_q;

  AST_ONE_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (ref_q == $past(ref_q)) || (ref_q == $past(ref_q) + 1'b1)
               || (ref_q == $past(ref_q) - 1'b1)); // R2
  AST_STILL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !run_i |=> $stable(ref_q)); // R3
endmodule

// File: rtl/vrs_top.sv
module vrs_top
  import vrs_pkg::*;
#(
  parameter int VID_W      = 8,
  parameter int CODE_W     = 9,
  parameter int DELAY_CYC  = 40,
  parameter int HOLD_CYC   = 20,
  parameter int STEP_CYC   = 3,
  parameter int BOOT_CODE  = 173,
  parameter int OVP_MARGIN = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              pwr_ok_i,
  input  logic [VID_W-1:0]  vid_i,
  input  logic              ov_i,
  input  logic              uv_i,
  output logic [CODE_W-1:0] ref_o,
  output logic [CODE_W-1:0] ovp_ref_o,
  output logic              ss_done_o,
  output logic              fault_o,
  output logic              drv_en_o
);
  localparam int TMR_MAX = (DELAY_CYC > HOLD_CYC) ? DELAY_CYC : HOLD_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  vrs_state_e        st_q, st_d;
  logic              tgt_off, tmr_done, trip, slew_run, slew_clr, tmr_run;
  logic [CODE_W-1:0] tgt, goal;
  logic [TMR_W-1:0]  tmr_last;

  vrs_vid_map #(
    .VID_W(VID_W), .CODE_W(CODE_W), .OFF_CODES(2), .MAX_CODE(256),
    .OVP_MARGIN(OVP_MARGIN)
  ) u_map (
    .vid_i(vid_i), .off_o(tgt_off), .tgt_o(tgt), .ovp_o(ovp_ref_o)
  );

  assign tmr_run  = (st_q == ST_DELAY) || (st_q == ST_HOLD);
  assign tmr_last = (st_q == ST_DELAY) ? TMR_W'(DELAY_CYC - 1) : TMR_W'(HOLD_CYC - 1);

  vrs_interval #(.CNT_W(TMR_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(tmr_run), .last_i(tmr_last),
    .done_o(tmr_done)
  );

  // OV window opens when the boot rest ends; UV only once regulating
  assign trip = (ov_i && (st_q inside {ST_SLEW, ST_RUN, ST_SHUT}))
             || (uv_i && (st_q == ST_RUN));

  always_comb begin
    st_d = st_q;
    if (!pwr_ok_i || !en_i) st_d = ST_IDLE;
    else if (trip)          st_d = ST_FAULT;
    else begin
      unique case (st_q)
        ST_IDLE:  st_d = ST_DELAY;
        ST_DELAY: if (tmr_done) st_d = ST_BOOT;
        ST_BOOT:  if (ref_o == CODE_W'(BOOT_CODE)) st_d = ST_HOLD;
        ST_HOLD:  if (tmr_done) st_d = tgt_off ? ST_SHUT : ST_SLEW;
        ST_SLEW:  if (ref_o == tgt) st_d = ST_RUN;
        default:  st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;

  assign slew_run = st_q inside {ST_BOOT, ST_SLEW, ST_RUN, ST_SHUT};
  assign slew_clr = (st_d == ST_IDLE) || (st_d == ST_FAULT);
  assign goal     = (st_q == ST_BOOT) ? CODE_W'(BOOT_CODE) :
                    (st_q == ST_SHUT) ? '0 : tgt;

  vrs_slew #(.CODE_W(CODE_W), .STEP_CYC(STEP_CYC)) u_slew (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(slew_clr), .run_i(slew_run),
    .goal_i(goal), .ref_o(ref_o)
  );

  assign ss_done_o = (st_q == ST_RUN);
  assign fault_o   = (st_q == ST_FAULT);
  assign drv_en_o  = st_q inside {ST_BOOT, ST_HOLD, ST_SLEW, ST_RUN};

  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && en_i && pwr_ok_i |=> fault_o); // R9
  AST_NO_EARLY_OV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q inside {ST_DELAY, ST_BOOT, ST_HOLD}) |=> !fault_o); // R7
  AST_DONE_AT_TGT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ss_done_o) |-> ref_o == $past(tgt)); // R4
  AST_PWR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> !fault_o && !drv_en_o && (ref_o == '0)); // R10
  AST_FAULT_DROPS_DRV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> ref_o == '0); // R7
endmodule

// File: tb/sim_vrs_top.sv
`timescale 1ns/1ps
module sim_vrs_top;
  localparam int DLY = 40, HLD = 20, STP = 3, BOOT = 173;
  localparam int S_IDLE = 0, S_DELAY = 1, S_BOOT = 2, S_HOLD = 3,
                 S_SLEW = 4, S_RUN = 5, S_SHUT = 6, S_FAULT = 7;

  logic clk = 0, rst_n = 0, en = 0, pok = 0, ov = 0, uv = 0;
  logic [7:0] vid = 8'h02;
  logic [8:0] ref_o, ovp_o;
  logic ss, flt, drv;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vrs_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pwr_ok_i(pok), .vid_i(vid),
    .ov_i(ov), .uv_i(uv), .ref_o(ref_o), .ovp_ref_o(ovp_o),
    .ss_done_o(ss), .fault_o(flt), .drv_en_o(drv)
  );

  function automatic int code_of(input int v);
    return (v < 2) ? 0 : 258 - v;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mst = S_IDLE, mref = 0, mstep = 0, mtmr = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst = S_IDLE; mref = 0; mstep = 0; mtmr = 0;
    end else begin
      int tg, nst, goal;
      bit trip, ramping;
      tg = code_of(vid);
      trip = (ov && (mst == S_SLEW || mst == S_RUN || mst == S_SHUT)) || (uv && mst == S_RUN);
      nst = mst;
      if (!pok || !en) nst = S_IDLE;
      else if (trip) nst = S_FAULT;
      else if (mst == S_IDLE) nst = S_DELAY;
      else if (mst == S_DELAY && mtmr == DLY - 1) nst = S_BOOT;
      else if (mst == S_BOOT && mref == BOOT) nst = S_HOLD;
      else if (mst == S_HOLD && mtmr == HLD - 1) nst = (vid < 2) ? S_SHUT : S_SLEW;
      else if (mst == S_SLEW && mref == tg) nst = S_RUN;
      ramping = (mst == S_BOOT || mst == S_SLEW || mst == S_RUN || mst == S_SHUT);
      goal = (mst == S_BOOT) ? BOOT : (mst == S_SHUT) ? 0 : tg;
      if (nst == S_IDLE || nst == S_FAULT) begin mref = 0; mstep = 0; end
      else if (!ramping) mstep = 0;
      else if (mstep == STP - 1) begin
        mstep = 0;
        if (mref < goal) mref++; else if (mref > goal) mref--;
      end else mstep++;
      mtmr = (mst == S_DELAY || mst == S_HOLD) ? mtmr + 1 : 0;
      mst = nst;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R4", "ref_o", ref_o, mref);
    chk("R4", "ss_done_o", ss, mst == S_RUN);
    chk("R7", "fault_o", flt, mst == S_FAULT);
    chk("R2", "drv_en_o", drv, (mst >= S_BOOT && mst <= S_RUN));
    chk("R11", "ovp_ref_o", ovp_o, code_of(vid) + 28);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    cyc(2);
    chk("R1", "reset ref", ref_o, 0);
    chk("R1", "reset flags", {ss, flt, drv}, 0);
    rst_n = 1;
    cyc(2);
    // startup to 0x02 (1.600 V)
    vid = 8'h02; pok = 1; en = 1;
    n = 0;
    while (ref_o == 0 && n < 1000) begin @(negedge clk); n++; end
    chk("R2", "cycles to first step", n, 1 + DLY + STP);
    n = 0;
    while (ref_o != BOOT && n < 2000) begin @(negedge clk); n++; end
    n = 1;
    while (ref_o == BOOT && n < 1000) begin @(negedge clk); n++; end
    chk("R3", "cycles at boot code", n - 1, HLD + STP + 1);
    n = 0;
    while (!ss && n < 2000) begin @(negedge clk); n++; end
    chk("R5", "final code 0x02", ref_o, 256);
    chk("R11", "ovp at 0x02", ovp_o, 284);
    // OV in run latches
    ov = 1; cyc(1); ov = 0;
    chk("R7", "fault after ov", flt, 1);
    chk("R7", "drv after ov", drv, 0);
    chk("R7", "ref after ov", ref_o, 0);
    cyc(10);
    chk("R9", "fault sticky", flt, 1);
    en = 0; cyc(1); en = 1; cyc(2);
    chk("R9", "fault cleared by en", flt, 0);
    // OV ignored during boot rest, then slew down to 0x80
    n = 0;
    while (ref_o != BOOT && n < 3000) begin @(negedge clk); n++; end
    cyc(2); ov = 1; cyc(5); ov = 0;
    chk("R7", "ov ignored in rest", flt, 0);
    vid = 8'h80;
    n = 0;
    while (ref_o != BOOT - 2 && n < 1000) begin @(negedge clk); n++; end
    uv = 1; cyc(3); uv = 0;
    chk("R8", "uv ignored in slew", flt, 0);
    n = 0;
    while (!ss && n < 2000) begin @(negedge clk); n++; end
    chk("R5", "final code 0x80", ref_o, 130);
    vid = 8'h83; cyc(1);
    chk("R4", "retarget holds done", ss, 1);
    cyc(4 * STP);
    chk("R4", "retarget tracked", ref_o, 127);
    uv = 1; cyc(1); uv = 0;
    chk("R8", "uv latches in run", flt, 1);
    // supply drop clears fault
    pok = 0; cyc(1);
    chk("R10", "pok drop fault", flt, 0);
    chk("R10", "pok drop ref", ref_o, 0);
    pok = 1;
    // VID off at end of rest
    vid = 8'h00;
    n = 0;
    while (ref_o != BOOT && n < 3000) begin @(negedge clk); n++; end
    n = 0;
    while (ref_o != 0 && n < 3000) begin @(negedge clk); n++; end
    cyc(5);
    chk("R6", "shut ref", ref_o, 0);
    chk("R6", "shut drv", drv, 0);
    chk("R6", "shut flags", {ss, flt}, 0);
    vid = 8'h01; cyc(1);
    chk("R5", "0x01 off ovp", ovp_o, 28);
    vid = 8'hFF; cyc(1);
    chk("R5", "0xFF ovp", ovp_o, 31);
    // supply drop in the middle of the boot ramp
    en = 0; cyc(1); en = 1; vid = 8'h10;
    cyc(1 + DLY + STP * 20);
    chk("R2", "mid ramp value", ref_o, 20);
    pok = 0; cyc(1);
    chk("R10", "drop mid ramp ref", ref_o, 0);
    chk("R10", "drop mid ramp drv", drv, 0);
    pok = 1; cyc(5);
    rst_n = 0; cyc(1);
    chk("R1", "reset again", {ss, flt, drv}, 0);
    finish_run();
  end
endmodule